// File: doc/BRIEF.md
# Sound Channel Parameter Decoder

This block sits behind a register bus and turns 32-bit writes into playback settings for up to 64 sound channels. The bus reaches the channels through two windows. Each window holds 32 channels, and each channel takes a 128-byte slice of its window. A write updates the stored settings of one channel: the 21-bit sample start address, the loop flag, the sample format, the loop start, the end address, the raw frequency word and the left and right volume.

A write to a channel's config register can also carry a key command. When it does, the block raises a one-clock key-on or key-off pulse together with the 6-bit channel number, which a playback engine downstream picks up. A separate combinational read port returns the stored settings of any one channel. Sample fetch, envelopes and mixing are handled by other blocks.

Top module: `snd_chan_decode`

## Requirements
- R1: A write goes to channel `wr_win*32 + wr_addr[11:7]`, and the byte offset within that channel is `wr_addr[6:0]`.
- R2: Only the low 16 bits of `wr_data` are used. Bits 31:16 have no effect on any setting.
- R3: A write to offset 0x00 sets start-address bits 20:16 from data bits 4:0 and sets the loop flag from data bit 9. Start bits 15:0 are left unchanged.
- R4: On an offset 0x00 write, data bits 8:7 set the format output `rd_fmt`. Code 0 gives 0 (16-bit PCM), code 1 gives 1 (8-bit PCM), and codes 2 and 3 both give 2 (ADPCM).
- R5: On an offset 0x00 write, data bits 15:14 are a command. Value 3 makes `key_on` high for exactly one cycle after the write. Value 2 does the same for `key_off`. Values 0 and 1 raise neither. `key_on` and `key_off` are never high together.
- R6: While a pulse is high, `key_ch` carries the 6-bit channel number of the write that caused it.
- R7: A write to offset 0x04 sets start-address bits 15:0 and keeps bits 20:16.
- R8: A write to offset 0x08 sets the loop start, offset 0x0C sets the end address, and offset 0x18 sets the frequency word. Each takes the full 16 bits of data.
- R9: A write to offset 0x28 sets both the left and the right volume from data bits 7:0.
- R10: Writes to offsets 0x10, 0x14, 0x1C, 0x20, 0x24 or any other offset change no setting and raise no pulse.
- R11: After reset every channel reads back all zero with looping off, and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 1 | Window select (0: channels 0-31, 1: channels 32-63) |
| wr_addr | input | 12 | Byte address within the window |
| wr_data | input | 32 | Write data |
| rd_ch | input | 6 | Channel to read back |
| rd_start | output | 21 | Sample start address |
| rd_loop | output | 1 | Loop enable |
| rd_fmt | output | 2 | Format: 0 16-bit PCM, 1 8-bit PCM, 2 ADPCM |
| rd_lstart | output | 16 | Loop start |
| rd_end | output | 16 | End address |
| rd_freq | output | 16 | Raw frequency word |
| rd_vol_l | output | 8 | Left volume |
| rd_vol_r | output | 8 | Right volume |
| key_on | output | 1 | One-cycle start pulse |
| key_off | output | 1 | One-cycle stop pulse |
| key_ch | output | 6 | Channel of the current pulse |

## Verification
The hardest case to reach is the split start address. The high and low halves reach the same channel through two different offsets, and each write must leave the other half untouched. The bench writes the low half first, then the high half, then the low half again with a new value, and checks the full 21-bit value after each write. It does this on a channel in the second window, so a wrong window offset would put the data on another channel. That other channel is then read back to confirm it is still zero.

// File: rtl/snd_chan_decode.sv
module snd_chan_decode #(
  parameter int CH_PER_WIN = 32,
  parameter int CH_BYTES   = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_win,
  input  logic [11:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [5:0]  rd_ch,
  output logic [20:0] rd_start,
  output logic        rd_loop,
  output logic [1:0]  rd_fmt,
  output logic [15:0] rd_lstart,
  output logic [15:0] rd_end,
  output logic [15:0] rd_freq,
  output logic [7:0]  rd_vol_l,
  output logic [7:0]  rd_vol_r,
  output logic        key_on,
  output logic        key_off,
  output logic [5:0]  key_ch
);
  localparam int NUM_CH = 2 * CH_PER_WIN;
  localparam int OFF_W  = $clog2(CH_BYTES);

  logic [20:0] start_q  [NUM_CH];
  logic        loop_q   [NUM_CH];
  logic [1:0]  fmt_q    [NUM_CH];
  logic [15:0] lstart_q [NUM_CH];
  logic [15:0] end_q    [NUM_CH];
  logic [15:0] freq_q   [NUM_CH];
  logic [7:0]  vol_q    [NUM_CH];

  wire [5:0]       ch  = {wr_win, wr_addr[OFF_W +: 5]};
  wire [OFF_W-1:0] off = wr_addr[OFF_W-1:0];
  wire [15:0]      d   = wr_data[15:0];
  wire             cfg = wr_en && off == 7'h00;
  wire [1:0]       fmt_dec = d[8] ? 2'd2 : {1'b0, d[7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        start_q[i]  <= '0;
        loop_q[i]   <= 1'b0;
        fmt_q[i]    <= '0;
        lstart_q[i] <= '0;
        end_q[i]    <= '0;
        freq_q[i]   <= '0;
        vol_q[i]    <= '0;
      end
    end else if (wr_en) begin
      case (off)
        7'h00: begin
          start_q[ch][20:16] <= d[4:0];
          loop_q[ch]         <= d[9];
          fmt_q[ch]          <= fmt_dec;
        end
        7'h04: start_q[ch][15:0] <= d;
        7'h08: lstart_q[ch]      <= d;
        7'h0C: end_q[ch]         <= d;
        7'h18: freq_q[ch]        <= d;
        7'h28: vol_q[ch]         <= d[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_on  <= 1'b0;
      key_off <= 1'b0;
      key_ch  <= '0;
    end else begin
      key_on  <= cfg && d[15:14] == 2'b11;
      key_off <= cfg && d[15:14] == 2'b10;
      if (cfg && d[15]) key_ch <= ch;
    end
  end

  assign rd_start  = start_q[rd_ch];
  assign rd_loop   = loop_q[rd_ch];
  assign rd_fmt    = fmt_q[rd_ch];
  assign rd_lstart = lstart_q[rd_ch];
  assign rd_end    = end_q[rd_ch];
  assign rd_freq   = freq_q[rd_ch];
  assign rd_vol_l  = vol_q[rd_ch];
  assign rd_vol_r  = vol_q[rd_ch];

  wire ign_off = !(off inside {7'h00, 7'h04, 7'h08, 7'h0C, 7'h18, 7'h28});

  assert_key_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_on && key_off));

  assert_key_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on || key_off) |-> $past(wr_en) && $past(wr_addr[OFF_W-1:0]) == 7'h00);

  assert_key_ch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on || key_off) |-> key_ch == {$past(wr_win), $past(wr_addr[OFF_W +: 5])});

  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ign_off) |=> !key_on && !key_off &&
      (!$stable(rd_ch) || ($stable(rd_start) && $stable(rd_lstart) && $stable(rd_end)
        && $stable(rd_freq) && $stable(rd_vol_l) && $stable(rd_loop))));

  assert_fmt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fmt != 2'd3);
endmodule

// File: tb/snd_chan_decode_tb.sv
module snd_chan_decode_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, wr_win = 0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_ch = '0;
  logic [20:0] rd_start;
  logic        rd_loop, key_on, key_off;
  logic [1:0]  rd_fmt;
  logic [15:0] rd_lstart, rd_end, rd_freq;
  logic [7:0]  rd_vol_l, rd_vol_r;
  logic [5:0]  key_ch;
  int checks = 0, fails = 0;

  snd_chan_decode u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic win, logic [5:0] c, logic [6:0] off, logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_win = win; wr_addr = {c[4:0], off}; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    rd_ch = 0;  #1;
    chk("R11", {rd_start, rd_loop, rd_fmt}, 0);
    chk("R11", {rd_lstart, rd_end, rd_freq, rd_vol_l}, 0);
    rd_ch = 63; #1;
    chk("R11", {rd_start, rd_loop, rd_vol_r}, 0);
    chk("R11", {key_on, key_off}, 0);
  endtask

  task automatic t_start_split;
    wr(1, 5, 7'h04, 32'h1234);
    rd_ch = 37; #1; chk("R7", rd_start, 21'h01234);
    wr(1, 5, 7'h00, 32'h0000_0015);
    #1; chk("R3", rd_start, 21'h151234);
    wr(1, 5, 7'h04, 32'hBEEF);
    #1; chk("R7", rd_start, 21'h15BEEF);
    rd_ch = 5; #1; chk("R1", rd_start, 0);
  endtask

  task automatic t_cfg;
    wr(0, 2, 7'h00, 32'h0000_0200);
    rd_ch = 2; #1; chk("R3", {rd_loop, rd_fmt}, {1'b1, 2'd0});
    wr(0, 2, 7'h00, 32'h0000_0080);
    #1; chk("R4", {rd_loop, rd_fmt}, {1'b0, 2'd1});
    wr(0, 2, 7'h00, 32'h0000_0100);
    #1; chk("R4", rd_fmt, 2);
    wr(0, 2, 7'h00, 32'h0000_0180);
    #1; chk("R4", rd_fmt, 2);
  endtask

  task automatic t_keys;
    @(negedge clk);
    wr_en = 1; wr_win = 1; wr_addr = {5'd31, 7'h00}; wr_data = 32'hC000;
    @(negedge clk); wr_en = 0;
    chk("R5", {key_on, key_off}, 2'b10);
    chk("R6", key_ch, 63);
    @(negedge clk);
    chk("R5", {key_on, key_off}, 2'b00);
    wr(0, 9, 7'h00, 32'h8000);
    chk("R5", {key_on, key_off}, 2'b01);
    chk("R6", key_ch, 9);
    wr(0, 9, 7'h00, 32'h4000);
    chk("R5", {key_on, key_off}, 2'b00);
    wr(0, 9, 7'h00, 32'h0000);
    chk("R5", {key_on, key_off}, 2'b00);
  endtask

  task automatic t_fields;
    wr(0, 20, 7'h08, 32'hFFFF_1111);
    wr(0, 20, 7'h0C, 32'h0000_2222);
    wr(0, 20, 7'h18, 32'hABCD_3333);
    wr(0, 20, 7'h28, 32'h0000_01A5);
    rd_ch = 20; #1;
    chk("R8", rd_lstart, 16'h1111);
    chk("R2", rd_freq, 16'h3333);
    chk("R8", rd_end, 16'h2222);
    chk("R9", {rd_vol_l, rd_vol_r}, 16'hA5A5);
  endtask

  task automatic t_ignored;
    wr(0, 20, 7'h10, 32'hFFFF);
    wr(0, 20, 7'h14, 32'hFFFF);
    wr(0, 20, 7'h1C, 32'hFFFF);
    wr(0, 20, 7'h20, 32'hFFFF);
    wr(0, 20, 7'h24, 32'hFFFF);
    wr(0, 20, 7'h40, 32'hFFFF);
    chk("R10", {key_on, key_off}, 0);
    rd_ch = 20; #1;
    chk("R10", {rd_start, rd_loop, rd_fmt}, 0);
    chk("R10", {rd_lstart, rd_end}, 32'h1111_2222);
    chk("R10", {rd_freq, rd_vol_l}, 24'h3333A5);
  endtask

  initial begin
    #5000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_start_split;
    t_cfg;
    t_keys;
    t_fields;
    t_ignored;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule